// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a direct-mapped first-level data cache paired with a small fully associative victim buffer. The buffer holds only lines that the first-level array has just thrown out. A line never sits in both structures at once. A load that misses the direct-mapped array is looked up in the victim entries. On a victim hit, the requested line and the line it displaces trade places in a single transaction, and the next level is not touched. When both structures miss, the line is fetched through a simple next-level port that answers after a fixed delay. In the reference setup that delay is 24 cycles. The fetched line is installed in the array, and any valid line it displaces drops into the victim buffer.

The CPU side takes one load at a time. A load is a byte address whose offset bits are ignored, and the response is the whole 16-byte line. Each response comes with exactly one outcome pulse (array hit, victim hit or full miss), so outcomes can be counted from outside. The victim buffer does not have to stay inclusive with the next level, and no invalidation ever arrives from it. Lines are read-only from this block's point of view.

Top module: `vc_dm_cache`

## Requirements
- R1: After reset, every array and victim entry is invalid, so the first load to any line is a full miss; `rsp_valid` and `mem_req_valid` are low and `req_ready` is high.
- R2: A load whose line is resident in the direct-mapped array returns that line with `ev_hit`, and `rsp_valid` rises one clock after the accepting edge. No next-level request is issued.
- R3: A load that misses both structures issues exactly one single-cycle `mem_req_valid` pulse carrying the line address (the byte address without its low 4 bits). It answers with `mem_rsp_data` and `ev_miss` on the clock after `mem_rsp_valid` is sampled.
- R4: On a full miss, the valid line previously held in the indexed array set is written into the victim buffer, so a later load of it is a victim hit.
- R5: A load found in the victim buffer returns the line with `ev_vhit` two clocks after the accepting edge, with no next-level request. The line it displaces from the array takes over that victim entry.
- R6: No line is ever present in both the array and the victim buffer, and at most one victim entry matches any line address.
- R7: A line inserted by a full miss goes into an invalid victim entry when one exists, and otherwise replaces the least recently used entry. A victim hit makes the swapped-in line the most recently used entry. Array hits leave the recency order unchanged.
- R8: Every response carries exactly one of `ev_hit`, `ev_vhit`, `ev_miss`, and no event pulse appears without a response.
- R9: `req_ready` is low from the accepting edge until the response cycle, and a request is taken only on an edge where `req_ready` is high.
- R10: The low 4 address bits (the byte offset within a 16-byte line) do not affect lookup or placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | ADDR_W | Load byte address |
| req_ready | output | 1 | Block idle and accepting a load |
| rsp_valid | output | 1 | Response line valid (one cycle) |
| rsp_data | output | 8*LINE_BYTES | Requested line |
| ev_hit | output | 1 | Response came from the direct-mapped array |
| ev_vhit | output | 1 | Response came from the victim buffer |
| ev_miss | output | 1 | Response came from the next level |
| mem_req_valid | output | 1 | Next-level fetch request pulse |
| mem_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address to fetch |
| mem_rsp_valid | input | 1 | Next-level line returned |
| mem_rsp_data | input | 8*LINE_BYTES | Returned line |

## Verification
Lost or duplicated line state shows up at the ports as a wrong outcome pulse on a later load. A victim entry that was dropped or overwritten turns an expected victim hit into a full miss with an extra next-level request. A wrong recency order evicts a different line, and the error only appears when the evicted line is loaded again. For that reason the bench predicts every load's outcome with a timestamp-based model and mixes random conflicting traffic, confined to a few sets, with directed eviction sequences. Response data and latency expose swap errors on the very load that triggers them.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SWAP,
    ST_FILL
  } vc_state_t;
endpackage

// File: rtl/vc_l1_store.sv
module vc_l1_store #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 12,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  logic [LINE_W-1:0] data_mem [SETS];
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [SETS-1:0]   valid_q;

  // tag and data arrays: plain synchronous read/write, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_idx] <= wr_data;
      tag_mem[wr_idx]  <= wr_tag;
    end
    if (rd_en) begin
      rd_data <= data_mem[rd_idx];
      rd_tag  <= tag_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
  parameter int N   = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [AW-1:0] touch_idx,
  output logic [AW-1:0] lru_idx
);
  logic [AW-1:0] age_q [N];
  logic [N-1:0]  is_new;

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        age_q[g] <= AW'(g);
      end else if (touch_en) begin
        if (touch_idx == AW'(g))
          age_q[g] <= '0;
        else if (age_q[g] < age_q[touch_idx])
          age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign is_new[g] = (age_q[g] == '0);
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == AW'(N-1)) lru_idx = AW'(i);
  end

  // R7: the ages stay a permutation, so exactly one entry is newest
  a_r7_one_newest: assert property (@(posedge clk) disable iff (rst)
    $onehot(is_new));
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 16,
  parameter int LINE_W  = 128,
  localparam int EW     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [EW-1:0]     hit_idx,
  output logic [LINE_W-1:0] hit_data,
  output logic [EW-1:0]     pick_idx,
  input  logic              wr_en,
  input  logic [EW-1:0]     wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [EW-1:0]      lru_idx;
  logic               any_free;
  logic [EW-1:0]      free_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (wr_en && wr_idx == EW'(g)) begin
        valid_q[g] <= wr_valid;
        tag_q[g]   <= wr_tag;
        data_q[g]  <= wr_data;
      end
    end
    assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_idx = EW'(i);
  end
  assign hit      = |match;
  assign hit_data = data_q[hit_idx];

  // lowest-numbered empty entry first, else least recently used
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = EW'(i);
      end
  end
  assign pick_idx = any_free ? free_idx : lru_idx;

  vc_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (wr_en),
    .touch_idx (wr_idx),
    .lru_idx   (lru_idx)
  );

  // R6: a line address never matches two entries
  a_r6_unique_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/vc_dm_cache.sv
module vc_dm_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int LINE_BYTES = 16,
  parameter int L1_SETS    = 16,
  parameter int VC_ENTRIES = 4,
  localparam int LINE_W    = 8 * LINE_BYTES,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(L1_SETS),
  localparam int TAG_W     = LA_W - IDX_W,
  localparam int EW        = $clog2(VC_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              ev_hit,
  output logic              ev_vhit,
  output logic              ev_miss,
  output logic              mem_req_valid,
  output logic [LA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  vc_state_t state;
  logic [LA_W-1:0]   req_line;
  logic [OFF_W-1:0]  unused_offset;

  logic              l1_rd_en, l1_rd_valid, l1_wr_en;
  logic [TAG_W-1:0]  l1_rd_tag;
  logic [LINE_W-1:0] l1_rd_data, l1_wr_data;
  logic              l1_hit;

  logic              vc_hit, vc_wr_en, vc_wr_valid;
  logic [EW-1:0]     vc_hit_idx, vc_pick_idx, vc_wr_idx;
  logic [LINE_W-1:0] vc_hit_data;

  logic              old_valid;
  logic [TAG_W-1:0]  old_tag;
  logic [LINE_W-1:0] old_data;
  logic [EW-1:0]     sw_idx;
  logic [LINE_W-1:0] sw_data;
  logic              fill_now;

  assign unused_offset = req_addr[OFF_W-1:0];
  assign req_ready = (state == ST_IDLE);
  assign l1_rd_en  = (state == ST_IDLE) && req_valid;
  assign l1_hit    = l1_rd_valid && (l1_rd_tag == req_line[LA_W-1:IDX_W]);
  assign fill_now  = (state == ST_FILL) && mem_rsp_valid;

  assign l1_wr_en   = (state == ST_SWAP) || fill_now;
  assign l1_wr_data = (state == ST_SWAP) ? sw_data : mem_rsp_data;

  // swap reuses the hit entry; a miss inserts only a valid displaced line
  assign vc_wr_en    = (state == ST_SWAP) || (fill_now && old_valid);
  assign vc_wr_idx   = (state == ST_SWAP) ? sw_idx : vc_pick_idx;
  assign vc_wr_valid = old_valid;

  vc_l1_store #(.SETS(L1_SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_l1 (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (l1_rd_en),
    .rd_idx   (req_addr[OFF_W +: IDX_W]),
    .rd_valid (l1_rd_valid),
    .rd_tag   (l1_rd_tag),
    .rd_data  (l1_rd_data),
    .wr_en    (l1_wr_en),
    .wr_idx   (req_line[IDX_W-1:0]),
    .wr_tag   (req_line[LA_W-1:IDX_W]),
    .wr_data  (l1_wr_data)
  );

  vc_victim_buf #(.ENTRIES(VC_ENTRIES), .TAG_W(LA_W), .LINE_W(LINE_W)) u_vc (
    .clk      (clk),
    .rst      (rst),
    .lk_tag   (req_line),
    .hit      (vc_hit),
    .hit_idx  (vc_hit_idx),
    .hit_data (vc_hit_data),
    .pick_idx (vc_pick_idx),
    .wr_en    (vc_wr_en),
    .wr_idx   (vc_wr_idx),
    .wr_valid (vc_wr_valid),
    .wr_tag   ({old_tag, req_line[IDX_W-1:0]}),
    .wr_data  (old_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      req_line      <= '0;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      ev_hit        <= 1'b0;
      ev_vhit       <= 1'b0;
      ev_miss       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      old_valid     <= 1'b0;
      old_tag       <= '0;
      old_data      <= '0;
      sw_idx        <= '0;
      sw_data       <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      ev_hit        <= 1'b0;
      ev_vhit       <= 1'b0;
      ev_miss       <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_line <= req_addr[ADDR_W-1:OFF_W];
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          old_valid <= l1_rd_valid;
          old_tag   <= l1_rd_tag;
          old_data  <= l1_rd_data;
          sw_idx    <= vc_hit_idx;
          sw_data   <= vc_hit_data;
          if (l1_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= l1_rd_data;
            ev_hit    <= 1'b1;
            state     <= ST_IDLE;
          end else if (vc_hit) begin
            state <= ST_SWAP;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= req_line;
            state         <= ST_FILL;
          end
        end
        ST_SWAP: begin
          rsp_valid <= 1'b1;
          rsp_data  <= sw_data;
          ev_vhit   <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rsp_data;
            ev_miss   <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a line found in the array is never also a victim entry
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK && l1_hit) |-> !vc_hit);
  // R8: each response carries exactly one outcome
  a_r8_one_event: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({ev_hit, ev_vhit, ev_miss}));
  // R8: no outcome pulse without a response
  a_r8_no_stray_event: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(ev_hit || ev_vhit || ev_miss));
  // R3: the fetch request is a single-cycle pulse
  a_r3_single_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  // R9: no new load is taken in the cycle a fetch is issued
  a_r9_busy_on_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
endmodule

// File: tb/tb_vc_dm_cache.sv
`timescale 1ns/1ps
module tb_vc_dm_cache;
  localparam int ADDR_W = 20;
  localparam int SETS   = 16;
  localparam int NV     = 4;
  localparam int LAT    = 24;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [19:0]  req_addr;
  logic         req_ready, rsp_valid, ev_hit, ev_vhit, ev_miss;
  logic [127:0] rsp_data;
  logic         mem_req_valid;
  logic [15:0]  mem_req_addr;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_data;

  int checks = 0, fails = 0, mem_reqs = 0;
  logic [15:0] last_mem_addr;
  bit done = 0;

  always #2.5 clk = ~clk;

  vc_dm_cache #(.ADDR_W(ADDR_W), .LINE_BYTES(16), .L1_SETS(SETS), .VC_ENTRIES(NV)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ev_hit(ev_hit), .ev_vhit(ev_vhit), .ev_miss(ev_miss),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  function automatic logic [127:0] line_data(logic [15:0] la);
    logic [31:0] h;
    h = {16'h0, la} * 32'h9E37_79B1;
    return {h, ~h, h ^ 32'hA5A5_5A5A, la, ~la};
  endfunction

  // next-level model: answers LAT cycles after a request
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        mem_reqs++;
        last_mem_addr = mem_req_addr;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = line_data(last_mem_addr);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // reference model: array tags, victim lines with use timestamps
  bit          m_l1v [SETS];
  logic [15:0] m_l1l [SETS];
  bit          m_vv  [NV];
  logic [15:0] m_vl  [NV];
  int          m_vs  [NV];
  int          stamp;

  task automatic model_reset();
    for (int i = 0; i < SETS; i++) m_l1v[i] = 0;
    for (int i = 0; i < NV; i++) begin m_vv[i] = 0; m_vs[i] = 0; end
    stamp = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);
  endtask

  // kind: 0 array hit, 1 victim hit, 2 full miss
  task automatic access(input logic [19:0] addr, input string lbl);
    logic [15:0] line;
    int set, kind, vk, act_kind, lat, m0, slot;
    string rq;
    line = addr[19:4];
    set  = int'(line[3:0]);
    kind = 2; vk = -1;
    if (m_l1v[set] && m_l1l[set] == line) kind = 0;
    else for (int i = 0; i < NV; i++)
      if (m_vv[i] && m_vl[i] == line) begin kind = 1; vk = i; end
    rq = (lbl != "") ? lbl : (kind == 0) ? "R2" : (kind == 1) ? "R5" : "R3";
    m0 = mem_reqs;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(posedge clk);
    #1 req_valid = 1'b0;
    chk(req_ready == 0, "R9", "req_ready while busy", req_ready, 0);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!rsp_valid && lat < 200);
    act_kind = ev_hit ? 0 : ev_vhit ? 1 : ev_miss ? 2 : 3;
    chk(rsp_valid == 1, rq, "response arrived", rsp_valid, 1);
    chk(act_kind == kind, rq, "outcome kind", act_kind, kind);
    chk(rsp_data == line_data(line), rq, "line data", rsp_data, line_data(line));
    chk((ev_hit + ev_vhit + ev_miss) == 1, "R8", "single event", {ev_hit, ev_vhit, ev_miss}, 0);
    if (kind == 0) chk(lat == 1, rq, "hit latency", lat, 1);
    if (kind == 1) chk(lat == 2, rq, "victim hit latency", lat, 2);
    chk(mem_reqs - m0 == (kind == 2 ? 1 : 0), rq, "fetch count", mem_reqs - m0, (kind == 2 ? 1 : 0));
    if (kind == 2) chk(last_mem_addr == line, "R3", "fetch address", last_mem_addr, line);
    // update model
    if (kind == 1) begin
      m_vl[vk] = m_l1l[set]; m_vv[vk] = m_l1v[set]; m_vs[vk] = ++stamp;
      m_l1l[set] = line; m_l1v[set] = 1;
    end else if (kind == 2) begin
      if (m_l1v[set]) begin
        slot = -1;
        for (int i = NV-1; i >= 0; i--) if (!m_vv[i]) slot = i;
        if (slot < 0) begin
          slot = 0;
          for (int i = 1; i < NV; i++) if (m_vs[i] < m_vs[slot]) slot = i;
        end
        m_vl[slot] = m_l1l[set]; m_vv[slot] = 1; m_vs[slot] = ++stamp;
      end
      m_l1l[set] = line; m_l1v[set] = 1;
    end
  endtask

  function automatic logic [19:0] mk(int tag, int set, int off);
    return {12'(tag), 4'(set), 4'(off)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: cold miss, then R2 hit, R10 offset ignored
    access(mk(1, 0, 0), "R1");
    access(mk(1, 0, 0), "R2");
    access(mk(1, 0, 15), "R10");
    // R4: conflicting line pushes the first into the victim buffer
    access(mk(2, 0, 4), "R3");
    access(mk(1, 0, 8), "R4");
    // R5: swap back; R6: line just moved out of the array is a victim hit
    access(mk(2, 0, 0), "R5");
    access(mk(2, 0, 3), "R6");
    access(mk(1, 0, 0), "R6");
    // R7: overflow the victim buffer in one set
    do_reset();
    for (int t = 1; t <= 6; t++) access(mk(t, 1, 0), "R7");
    access(mk(1, 1, 0), "R7");
    access(mk(3, 1, 0), "R7");
    access(mk(9, 1, 0), "R7");
    access(mk(2, 1, 0), "R7");
    access(mk(4, 1, 0), "R7");
    // R1: reset clears everything
    do_reset();
    access(mk(4, 1, 0), "R1");
    // random conflicting traffic
    for (int n = 0; n < 400; n++)
      access(mk($urandom_range(1, 6), $urandom_range(0, 3), $urandom_range(0, 15)), "");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule